// File: doc/BRIEF.md
# Serial Byte Transmitter with Valid/Busy Handshake

This block turns a parallel byte into an asynchronous serial frame on a single output line. The frame is one low start bit, the data bits with the least significant bit first, and one high stop bit. Between frames the line rests high. Each bit lasts `CLKS_PER_BIT` clock cycles, timed by a modulo-N counter that is cleared whenever the controller is idle. The first bit therefore always gets a full period.

The design has two halves joined only by a small strobe bundle. The first is a four-state controller with the states idle, start, data and stop. The second is a datapath made of a right-shifting register, an output select mux and a registered line driver. The controller issues a load strobe, a shift strobe and a line-select code, and the datapath acts on them.

Upstream logic places a byte on `tx_data` and raises `tx_valid`. The byte is taken on a clock edge where `tx_valid` is high and `tx_busy` is low. `tx_busy` then stays high for the whole frame. If `tx_valid` is held high, the next byte is taken in the single idle cycle that follows each frame.

Top module: `uart_tx_core`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `tx_line` is 1 and `tx_busy` is 0.
- R2: With no accepted request, `tx_line` stays at 1. After every frame it returns to 1 and stays there until the next accepted request.
- R3: A byte is taken only on a rising edge where `tx_valid`=1 and `tx_busy`=0. A `tx_valid` pulse while `tx_busy`=1 starts no frame, and its data is never sent.
- R4: The start bit (`tx_line`=0) begins one clock after the accepting edge and lasts exactly `CLKS_PER_BIT` cycles.
- R5: After the start bit, the `DATA_BITS` bits of the accepted byte appear in order from bit 0 up to bit `DATA_BITS-1`. Each bit lasts `CLKS_PER_BIT` cycles.
- R6: After the last data bit, `tx_line` is 1 for at least `CLKS_PER_BIT` cycles (the stop bit).
- R7: `tx_busy` rises on the edge that accepts a byte and stays high for exactly `(DATA_BITS+2)*CLKS_PER_BIT` cycles.
- R8: While `tx_valid` is held high, `tx_busy` is low for exactly one cycle between two frames. The next byte is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | DATA_BITS | Byte to send, taken on acceptance |
| tx_valid | input | 1 | Request to send `tx_data` |
| tx_busy | output | 1 | High while a frame is in progress |
| tx_line | output | 1 | Registered serial output, idle high |

## Verification
Two events can fall in the same cycle. One is the end of one frame's stop bit. The other is a new request that is already waiting. The request must be refused while the stop state is still active, and taken in the idle cycle that follows. The bench provokes this by holding `tx_valid` high through a back-to-back sweep of all 256 byte values, changing `tx_data` only in the cycle when busy is low. It judges the result in three ways: by decoding every frame at mid-bit against the byte it recorded at acceptance, by timing each busy period, and by requiring exactly one low-busy cycle between frames. A separate step pulses `tx_valid` with a different byte in the middle of a frame. It then confirms that no extra frame ever appears on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        SEL_REST  = 2'd0,
        SEL_LOW   = 2'd1,
        SEL_SHIFT = 2'd2,
        SEL_HIGH  = 2'd3
    } line_sel_e;

    typedef struct packed {
        logic      load;
        logic      shift;
        line_sel_e sel;
    } dp_ctrl_t;

    function automatic logic line_level(line_sel_e sel, logic dbit);
        logic lvl;
        case (sel)
            SEL_LOW:   lvl = 1'b0;
            SEL_SHIFT: lvl = dbit;
            default:   lvl = 1'b1;
        endcase
        return lvl;
    endfunction

    function automatic line_sel_e sel_for_state(tx_state_e st);
        line_sel_e s;
        case (st)
            ST_START: s = SEL_LOW;
            ST_DATA:  s = SEL_SHIFT;
            ST_STOP:  s = SEL_HIGH;
            default:  s = SEL_REST;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !clr && (cnt_q == LAST);

    // R4: after a tick the next period starts from zero
    assert_tick_wraps_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> (cnt_q == '0));

    // R4: a cleared counter restarts at zero
    assert_clear_restarts_R4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
    import uart_tx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     valid,
    input  logic     tick,
    output logic     busy,
    output logic     baud_clr,
    output dp_ctrl_t ctl
);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

    tx_state_e     state_q, state_d;
    logic [BW-1:0] bit_q;
    logic          last_bit;

    assign last_bit = (bit_q == LAST_BIT);

    always_comb begin
        state_d   = state_q;
        ctl.load  = 1'b0;
        ctl.shift = 1'b0;
        ctl.sel   = sel_for_state(state_q);
        case (state_q)
            ST_IDLE: begin
                if (valid) begin
                    state_d  = ST_START;
                    ctl.load = 1'b1;
                end
            end
            ST_START: begin
                if (tick) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (tick) begin
                    if (last_bit) state_d   = ST_STOP;
                    else          ctl.shift = 1'b1;
                end
            end
            ST_STOP: begin
                if (tick) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DATA && tick) begin
                bit_q <= last_bit ? '0 : bit_q + 1'b1;
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign baud_clr = (state_q == ST_IDLE);

    // R3: a request in idle always starts a frame
    assert_accept_starts_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && valid) |=> (state_q == ST_START));

    // R3: a request while busy never reloads the datapath
    assert_no_load_busy_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ctl.load);

    // R4: the start state holds until the bit period ends
    assert_start_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && !tick) |=> (state_q == ST_START));

    // R5: the bit index is zero outside the data state
    assert_bitcnt_rest_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_DATA) |-> (bit_q == '0));

    // R5: load and shift are never issued together
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(ctl.load && ctl.shift));

    // R6: the stop state always leads back to idle on its tick
    assert_stop_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && tick) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
    import uart_tx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_BITS-1:0] data,
    input  dp_ctrl_t             ctl,
    output logic                 line
);
    logic [DATA_BITS-1:0] sr_q;
    logic                 line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            line_q <= 1'b1;
        end else begin
            if (ctl.load) begin
                sr_q <= data;
            end else if (ctl.shift) begin
                sr_q <= {1'b0, sr_q[DATA_BITS-1:1]};
            end
            line_q <= line_level(ctl.sel, sr_q[0]);
        end
    end

    assign line = line_q;

    // R5: a load captures the byte presented with it
    assert_load_capture_R5: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (sr_q == $past(data)));

    // R5: a shift moves the next bit into position zero
    assert_shift_right_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.shift && !ctl.load) |=> (sr_q[0] == $past(sr_q[1])));

    // R2: the resting selection keeps the line high
    assert_rest_high_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl.sel == SEL_REST) |=> line_q);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_busy,
    output logic                 tx_line
);
    localparam int FRAME_CLKS = (DATA_BITS + 2) * CLKS_PER_BIT;

    logic     tick;
    logic     baud_clr;
    dp_ctrl_t ctl;

    uart_baud_gen #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .clr  (baud_clr),
        .tick (tick)
    );

    uart_tx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .valid    (tx_valid),
        .tick     (tick),
        .busy     (tx_busy),
        .baud_clr (baud_clr),
        .ctl      (ctl)
    );

    uart_tx_dp #(.DATA_BITS(DATA_BITS)) u_dp (
        .clk  (clk),
        .rst  (rst),
        .data (tx_data),
        .ctl  (ctl),
        .line (tx_line)
    );

    // checker-only counter of the current busy run
    int busy_len_q;
    always_ff @(posedge clk) begin
        if (rst)          busy_len_q <= 0;
        else if (tx_busy) busy_len_q <= busy_len_q + 1;
        else              busy_len_q <= 0;
    end

    // R7: every busy period lasts exactly one frame
    assert_busy_length_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> (busy_len_q == FRAME_CLKS));

    // R2: a low line is always preceded by a busy cycle
    assert_low_needs_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !tx_line |-> $past(tx_busy));

    // R1: reset leaves the line high and busy low
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (tx_line && !tx_busy));

endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
    localparam int N  = 4;
    localparam int DB = 8;
    localparam int FRAME = (DB + 2) * N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DB-1:0] tx_data = '0;
    logic          tx_valid = 1'b0;
    logic          tx_busy;
    logic          tx_line;

    int checks = 0;
    int errors = 0;

    logic [DB-1:0] exp_mem [0:511];
    int  wr_idx = 0;
    int  rd_idx = 0;
    bit  mon_en = 1'b0;
    bit  b2b    = 1'b0;

    always #2 clk = ~clk;

    uart_tx_core #(.CLKS_PER_BIT(N), .DATA_BITS(DB)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_busy  (tx_busy),
        .tx_line  (tx_line)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // frame decoder, samples at the middle of every bit
    initial begin
        logic [DB-1:0] rx;
        wait (mon_en);
        forever begin
            @(negedge clk);
            if (tx_line == 1'b0) begin
                repeat (N/2) @(negedge clk);
                check(tx_line == 1'b0, "R4 start bit low at mid", int'(tx_line), 0);
                for (int i = 0; i < DB; i++) begin
                    repeat (N) @(negedge clk);
                    rx[i] = tx_line;
                end
                repeat (N) @(negedge clk);
                check(tx_line == 1'b1, "R6 stop bit high at mid", int'(tx_line), 1);
                if (rd_idx < wr_idx) begin
                    check(rx == exp_mem[rd_idx], "R5 decoded byte", int'(rx), int'(exp_mem[rd_idx]));
                end else begin
                    check(1'b0, "R3 unexpected frame", int'(rx), -1);
                end
                rd_idx++;
            end
        end
    end

    // busy period and inter-frame gap timing
    initial begin
        bit prev = 1'b0;
        bit seen_fall = 1'b0;
        int hi_run = 0;
        int lo_run = 0;
        wait (mon_en);
        forever begin
            @(negedge clk);
            if (tx_busy) begin
                if (!prev && seen_fall && b2b)
                    check(lo_run == 1, "R8 one idle cycle between frames", lo_run, 1);
                if (!prev) hi_run = 0;
                hi_run++;
            end else begin
                if (prev) begin
                    check(hi_run == FRAME, "R7 busy length", hi_run, FRAME);
                    seen_fall = 1'b1;
                    lo_run = 0;
                end
                lo_run++;
            end
            prev = tx_busy;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit idle_ok;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tx_line == 1'b1, "R1 line high in reset", int'(tx_line), 1);
        check(tx_busy == 1'b0, "R1 busy low in reset", int'(tx_busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line == 1'b1 && tx_busy == 1'b0, "R1 state after reset",
              int'({tx_line, tx_busy}), 2);
        mon_en = 1'b1;

        idle_ok = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (tx_line != 1'b1 || tx_busy) idle_ok = 1'b0;
        end
        check(idle_ok, "R2 idle line with no request", int'(idle_ok), 1);

        // back-to-back sweep of every byte with valid held high
        b2b = 1'b1;
        for (int v = 0; v < 256; v++) begin
            while (tx_busy) @(negedge clk);
            tx_data  = DB'(v);
            tx_valid = 1'b1;
            exp_mem[wr_idx] = DB'(v);
            wr_idx++;
            @(negedge clk);
            check(tx_busy == 1'b1, "R7 busy after accept", int'(tx_busy), 1);
            check(tx_line == 1'b1, "R4 line still high on accept cycle", int'(tx_line), 1);
            @(negedge clk);
            check(tx_line == 1'b0, "R4 start one clock after accept", int'(tx_line), 0);
        end
        tx_valid = 1'b0;
        while (tx_busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check(rd_idx == 256, "R5 frames decoded in sweep", rd_idx, 256);
        b2b = 1'b0;

        // request while busy must be ignored
        repeat (5) @(negedge clk);
        tx_data  = 8'hA5;
        tx_valid = 1'b1;
        exp_mem[wr_idx] = 8'hA5;
        wr_idx++;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (3*N) @(negedge clk);
        tx_data  = 8'h3C;
        tx_valid = 1'b1;
        repeat (3*N) @(negedge clk);
        tx_valid = 1'b0;
        check(tx_busy == 1'b1, "R3 still in first frame", int'(tx_busy), 1);
        while (tx_busy) @(negedge clk);

        idle_ok = 1'b1;
        repeat (12*N) begin
            @(negedge clk);
            if (tx_line != 1'b1 || tx_busy) idle_ok = 1'b0;
        end
        check(idle_ok, "R2 line rests high after frame", int'(idle_ok), 1);
        check(rd_idx == wr_idx, "R3 no frame from request while busy", rd_idx, wr_idx);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule